// File: doc/BRIEF.md
# Dual bidirectional I/O port with load-only direction control

This block gives a small processor core two memory-mapped pin ports: a 4-pin port at register address 05h and an 8-pin port at register address 06h. Each pin has an output data latch, written over the register bus, and an input path that samples the pin through a two-flop synchronizer. A register-bus read returns the synchronized pin levels, not the latch contents.

Each port also has a direction register. It cannot be read, and no bus write reaches it. It is loaded only by a dedicated direction-load strobe, which copies the core's working value into the port picked by a 3-bit select. A direction bit of 0 makes the pin an output and a bit of 1 makes it an input. The lowest pin of the 4-pin port and pin 1 of the 8-pin port are open-drain: they can pull their line low but never drive it high. The pin side shows each pin's drive value and output enable, so that a pad ring can build the real buffer.

Top module: `dual_port_io`

## Requirements
- R1: After a synchronous active-low reset, both direction registers hold all ones, so every `*_oe` bit is 0, and both output latches hold 0.
- R2: On a push-pull pin whose direction bit is 0, the output enable is 1 and the drive value equals the latched bit.
- R3: A direction register changes only in the cycle after `dir_load` is high with `dir_sel` equal to 5 (4-pin port) or 6 (8-pin port). Other select values, and bus writes to any address, leave both direction registers unchanged.
- R4: A read of address 05h returns 1 in bits 7..4 and the synchronized pin levels in bits 3..0.
- R5: Open-drain pins (bit 0 of port A, bit 1 of port B) always have a drive value of 0. Their enable is 1 only when the direction bit is 0 and the latched bit is 0.
- R6: A read of address 05h or 06h returns the pin level sampled through two flops. A pin change made between edges appears on `bus_rdata` after the second following rising edge, and the latch value never appears there.
- R7: A bus write to a port whose pins are inputs updates the latch without enabling any output. The stored value drives the pin once its direction bit becomes 0.
- R8: A bus write to 05h or 06h loads the latch at the next rising edge. Port A takes write-data bits 3..0.
- R9: A read of any address other than 05h and 06h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Register address for read and write |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr |
| dir_load | input | 1 | Direction-load strobe from the instruction decoder |
| dir_sel | input | 3 | Register field of the direction-load instruction |
| dir_wval | input | 8 | Working value copied into the selected direction register |
| pa_in | input | 4 | Port A pin levels |
| pa_out | output | 4 | Port A drive values |
| pa_oe | output | 4 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |

## Verification
The hardest case to reach is one where the latch, the direction bit and the open-drain release all interact. The open-drain enable must turn off only when the latched bit goes to 1 while the pin is already an output. This needs a latch write made while the pins are inputs, then a direction load, then a second latch write, with the enables checked after each step. The stimulus also changes a pin between edges and reads it on both following cycles, to show the two-flop latency. It then issues direction loads with non-port select values and bus writes to other addresses, and checks that every enable is unchanged.

// File: rtl/io_port_pkg.sv
// Package: shared constants for the dual I/O port block.
// Assumes a 7-bit register address space and 8-bit data.
package io_port_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int A_PINS   = 4;
    localparam int B_PINS   = 8;
    localparam logic [ADDR_W-1:0] A_ADDR = 7'h05;
    localparam logic [ADDR_W-1:0] B_ADDR = 7'h06;
    localparam logic [A_PINS-1:0] A_OD   = 4'b0001;
    localparam logic [B_PINS-1:0] B_OD   = 8'b0000_0010;
endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Two-flop synchronizer for asynchronous pin levels.
// Assumes the inputs are level signals; both stages clear on reset.
module pin_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    // Count cycles since reset so that the latency check looks back no further than reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_SYNC_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (q == $past(d, 2))); // R6
endmodule

// File: rtl/port_bank.sv
// Module: port_bank
// One pin port: output latch, load-only direction register, per-pin
// push-pull or open-drain drive, and a synchronized read value.
// Assumes the parent decodes the write strobes. Read bits above W are 1.
module port_bank #(
    parameter int            W      = 4,
    parameter int            DW     = 8,
    parameter logic [W-1:0]  OD     = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_we,
    input  logic [W-1:0]  lat_wdata,
    input  logic          dir_we,
    input  logic [W-1:0]  dir_wdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [DW-1:0] rd_val
);
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] sampled;

    // Output data latch, loaded by register-bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (lat_we) lat_q <= lat_wdata;
    end

    // Direction register, loaded only by the direction-load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (dir_we) dir_q <= dir_wdata;
    end

    pin_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sampled)
    );

    // Per-pin driver: open-drain pins only pull low.
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (OD[i]) begin : g_od
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = ~dir_q[i] & ~lat_q[i];
        end else begin : g_pp
            assign pin_out[i] = lat_q[i];
            assign pin_oe[i]  = ~dir_q[i];
        end
    end

    // Read value: sampled pins, unused upper bits read as one.
    if (W < DW) begin : g_pad
        assign rd_val = {{(DW-W){1'b1}}, sampled};
    end else begin : g_full
        assign rd_val = sampled;
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(dir_q)); // R3
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> (dir_q == $past(dir_wdata))); // R3
    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> (lat_q == $past(lat_wdata))); // R8
endmodule

// File: rtl/dual_port_io.sv
// Module: dual_port_io
// Top: two pin ports on a register bus, with a direction-load path
// driven by the instruction decoder.
// Assumes the reads are combinational on bus_addr and the writes take effect at the next edge.
module dual_port_io
    import io_port_pkg::*;
#(
    parameter int                  P_ADDR_W = ADDR_W,
    parameter int                  P_DATA_W = DATA_W,
    parameter int                  P_SEL_W  = SEL_W,
    parameter int                  P_A_PINS = A_PINS,
    parameter int                  P_B_PINS = B_PINS,
    parameter logic [P_ADDR_W-1:0] P_A_ADDR = A_ADDR,
    parameter logic [P_ADDR_W-1:0] P_B_ADDR = B_ADDR,
    parameter logic [P_A_PINS-1:0] P_A_OD   = A_OD,
    parameter logic [P_B_PINS-1:0] P_B_OD   = B_OD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    input  logic                dir_load,
    input  logic [P_SEL_W-1:0]  dir_sel,
    input  logic [P_DATA_W-1:0] dir_wval,
    input  logic [P_A_PINS-1:0] pa_in,
    output logic [P_A_PINS-1:0] pa_out,
    output logic [P_A_PINS-1:0] pa_oe,
    input  logic [P_B_PINS-1:0] pb_in,
    output logic [P_B_PINS-1:0] pb_out,
    output logic [P_B_PINS-1:0] pb_oe
);
    localparam logic [P_SEL_W-1:0] A_SEL = P_A_ADDR[P_SEL_W-1:0];
    localparam logic [P_SEL_W-1:0] B_SEL = P_B_ADDR[P_SEL_W-1:0];

    logic a_lat_we, b_lat_we, a_dir_we, b_dir_we;
    logic [P_DATA_W-1:0] a_rd, b_rd;

    // Decode bus writes and direction loads per port.
    always_comb begin
        a_lat_we = bus_wr   && (bus_addr == P_A_ADDR);
        b_lat_we = bus_wr   && (bus_addr == P_B_ADDR);
        a_dir_we = dir_load && (dir_sel  == A_SEL);
        b_dir_we = dir_load && (dir_sel  == B_SEL);
    end

    port_bank #(.W(P_A_PINS), .DW(P_DATA_W), .OD(P_A_OD)) u_port_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (a_lat_we),
        .lat_wdata (bus_wdata[P_A_PINS-1:0]),
        .dir_we    (a_dir_we),
        .dir_wdata (dir_wval[P_A_PINS-1:0]),
        .pin_in    (pa_in),
        .pin_out   (pa_out),
        .pin_oe    (pa_oe),
        .rd_val    (a_rd)
    );

    port_bank #(.W(P_B_PINS), .DW(P_DATA_W), .OD(P_B_OD)) u_port_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (b_lat_we),
        .lat_wdata (bus_wdata[P_B_PINS-1:0]),
        .dir_we    (b_dir_we),
        .dir_wdata (dir_wval[P_B_PINS-1:0]),
        .pin_in    (pb_in),
        .pin_out   (pb_out),
        .pin_oe    (pb_oe),
        .rd_val    (b_rd)
    );

    // Read mux: port addresses return their sampled pins, all others return zero.
    always_comb begin
        if (bus_addr == P_A_ADDR)      bus_rdata = a_rd;
        else if (bus_addr == P_B_ADDR) bus_rdata = b_rd;
        else                           bus_rdata = '0;
    end

    if (P_A_PINS < P_DATA_W) begin : g_chk_pad
        AST_A_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == P_A_ADDR) |-> (&bus_rdata[P_DATA_W-1:P_A_PINS])); // R4
    end
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr != P_A_ADDR) && (bus_addr != P_B_ADDR)) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/tb_dual_port_io.sv
// Scoreboard bench: the driver pushes expected items, and the monitor pops them at the sample point.
module tb_dual_port_io;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dir_load = 1'b0;
    logic [2:0] dir_sel = '0;
    logic [7:0] dir_wval = '0;
    logic [3:0] pa_in = 4'hA;
    logic [3:0] pa_out, pa_oe;
    logic [7:0] pb_in = 8'h5C;
    logic [7:0] pb_out, pb_oe;

    always #2.5 clk = ~clk; // 200 MHz

    dual_port_io dut (.*);

    typedef struct { string req; int sig; logic [7:0] exp; } item_t;
    item_t sb_q[$];
    int total = 0, bad = 0;
    bit done = 0;

    function automatic logic [7:0] observe(int s);
        case (s)
            0: return bus_rdata;
            1: return {4'h0, pa_oe};
            2: return {4'h0, pa_out};
            3: return pb_oe;
            default: return pb_out;
        endcase
    endfunction

    task automatic push(string req, int sig, logic [7:0] exp);
        item_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(logic [6:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic dir_write(logic [2:0] s, logic [7:0] v);
        dir_sel = s; dir_wval = v; dir_load = 1'b1;
        tick();
        dir_load = 1'b0;
    endtask

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = observe(it.sig);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sig%0d actual=%02h expected=%02h", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        bus_addr = 7'h05;
        tick();
        push("R1", 1, 8'h00); push("R1", 3, 8'h00);
        push("R4", 0, 8'hFA);
        tick();
        // Latch written while pins are inputs: no drive, read shows pins.
        bus_write(7'h05, 8'h36);
        push("R7", 1, 8'h00);
        push("R6", 0, 8'hFA);
        tick();
        // Switch port A to outputs: latch 0110 appears; open-drain bit0 pulls low.
        dir_write(3'd5, 8'h00);
        push("R7", 1, 8'h0F); push("R2", 2, 8'h06);
        tick();
        // Latch bit0 = 1 releases the open-drain pin.
        bus_write(7'h05, 8'h01);
        push("R5", 1, 8'h0E); push("R5", 2, 8'h00); push("R8", 1, 8'h0E);
        tick();
        // Non-port selects and bus writes elsewhere change nothing.
        dir_write(3'd3, 8'hFF);
        dir_write(3'd0, 8'h00);
        bus_write(7'h04, 8'hFF);
        push("R3", 1, 8'h0E); push("R3", 3, 8'h00);
        bus_addr = 7'h03;
        tick();
        push("R9", 0, 8'h00);
        tick();
        // Port B: latch ones, low nibble outputs; OD bit1 latched 1 is released.
        bus_write(7'h06, 8'hFF);
        dir_write(3'd6, 8'hF0);
        push("R2", 3, 8'h0D); push("R5", 4, 8'hFD);
        tick();
        bus_write(7'h06, 8'h00);
        push("R5", 3, 8'h0F); push("R8", 4, 8'h00);
        tick();
        // Synchronizer latency on port B.
        bus_addr = 7'h06;
        tick();
        push("R6", 0, 8'h5C);
        pb_in = 8'h81;
        tick();
        push("R6", 0, 8'h5C);
        tick();
        push("R6", 0, 8'h81);
        tick();
        // Port A upper bits stay one with a new pin value.
        bus_addr = 7'h05;
        pa_in = 4'h5;
        tick(3);
        push("R4", 0, 8'hF5);
        tick(2);
        // Reset restores inputs and cleared latches.
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick();
        push("R1", 1, 8'h00); push("R1", 3, 8'h00);
        dir_write(3'd6, 8'h00);
        push("R1", 4, 8'h00);
        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule